// File: doc/BRIEF.md
# Page Access Permission and Reference/Change Checker

This block judges whether a memory access may use a leaf page-table entry. It takes a 64-bit leaf entry together with three access attributes: whether the access runs privileged, whether it is a store, and whether it is an instruction fetch. From these it decides two things. The first is whether the entry's access rights allow the access. The second is whether the entry's reference and change bits are already in a state that permits the access to go ahead without an update.

Inputs are captured when `req_valid_i` is high. The registered verdict appears one clock later with `rsp_valid_o` high. A new request can be taken every cycle. A translation walker uses the verdict to raise the correct fault, or to go on and fill its TLB. When no request is captured, the verdict outputs keep their last values.

Top module: `pte_perm_check`

## Requirements
- R1: `rsp_valid_o` is high in exactly the cycle after each cycle in which `req_valid_i` was high, and low otherwise; back-to-back requests each get their own response.
- R2: When `priv_i` is low and entry bit 3 (privileged-only) is set, `perm_ok_o` is low whatever the other entry bits are.
- R3: For a data access (`fetch_i` low) that passes R2, `perm_ok_o` is high when entry bit 1 (read/write) is set, or when entry bit 2 (read) is set and `store_i` is low.
- R4: For an instruction fetch (`fetch_i` high) that passes R2, `perm_ok_o` is high only when entry bit 0 (execute) is set and entry bit 5 is clear. Entry bits 5:4 form the attribute field (00 normal memory, 10 non-idempotent, 11 tolerant I/O), so a fetch from a cache-inhibited page is refused. Bits 1 and 2 and `store_i` do not affect fetch permission.
- R5: `rc_ok_o` is high when entry bit 8 (reference) is set and, for a store, entry bit 7 (change) is also set. This holds for fetches and data accesses alike.
- R6: `err_o` is 2'b00 when both verdicts pass, 2'b01 when permission fails (even when RC also fails), and 2'b10 when only RC fails.
- R7: In a cycle after which no request was captured, `perm_ok_o`, `rc_ok_o` and `err_o` keep their previous values.
- R8: While `rst_ni` is low, `rsp_valid_o`, `perm_ok_o` and `rc_ok_o` are 0 and `err_o` is 2'b00.
- R9: Entry bits other than 0, 1, 2, 3, 5, 7 and 8 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe; inputs captured on this cycle |
| pte_i | input | PTE_W | Leaf page-table entry |
| priv_i | input | 1 | Access is privileged |
| store_i | input | 1 | Access is a store |
| fetch_i | input | 1 | Access is an instruction fetch |
| rsp_valid_o | output | 1 | Verdict valid this cycle |
| perm_ok_o | output | 1 | Access rights allow the access |
| rc_ok_o | output | 1 | Reference/change bits allow the access |
| err_o | output | 2 | Cause: 00 none, 01 permission, 10 RC |

## Verification
The bench builds the block with its default 64-bit entry width. That width keeps every tested field position at its real place, with reserved bits above bit 8 available for the R9 checks. Randomizing the full entry together with all three access flags covers each combination of the privileged-only gate, the execute/cache-inhibit pairing and the store-dependent change bit. Randomly dropping the request strobe exercises back-to-back responses and the hold behaviour.

// File: rtl/pte_perm_pkg.sv
package pte_perm_pkg;
  typedef enum logic [1:0] {
    ERR_NONE = 2'b00,
    ERR_PERM = 2'b01,
    ERR_RC   = 2'b10
  } pte_err_e;

  localparam int unsigned BIT_EXEC  = 0;
  localparam int unsigned BIT_RW    = 1;
  localparam int unsigned BIT_RD    = 2;
  localparam int unsigned BIT_PRIV  = 3;
  localparam int unsigned BIT_CINH  = 5;  // upper attribute bit
  localparam int unsigned BIT_CHG   = 7;
  localparam int unsigned BIT_REF   = 8;
endpackage

// File: rtl/pte_access_eval.sv
module pte_access_eval
  import pte_perm_pkg::*;
#(
  parameter int unsigned PTE_W = 64
) (
  input  logic [PTE_W-1:0] pte_i,
  input  logic             priv_i,
  input  logic             store_i,
  input  logic             fetch_i,
  output logic             perm_ok_o
);
  logic gate_ok, data_ok, exec_ok;

  always_comb begin
    gate_ok   = priv_i | ~pte_i[BIT_PRIV];
    data_ok   = pte_i[BIT_RW] | (pte_i[BIT_RD] & ~store_i);
    exec_ok   = pte_i[BIT_EXEC] & ~pte_i[BIT_CINH];
    perm_ok_o = gate_ok & (fetch_i ? exec_ok : data_ok);
  end
endmodule

// File: rtl/pte_rc_eval.sv
module pte_rc_eval
  import pte_perm_pkg::*;
#(
  parameter int unsigned PTE_W = 64
) (
  input  logic [PTE_W-1:0] pte_i,
  input  logic             store_i,
  output logic             rc_ok_o
);
  always_comb rc_ok_o = pte_i[BIT_REF] & (pte_i[BIT_CHG] | ~store_i);
endmodule

// File: rtl/pte_perm_check.sv
module pte_perm_check
  import pte_perm_pkg::*;
#(
  parameter int unsigned PTE_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [PTE_W-1:0] pte_i,
  input  logic             priv_i,
  input  logic             store_i,
  input  logic             fetch_i,
  output logic             rsp_valid_o,
  output logic             perm_ok_o,
  output logic             rc_ok_o,
  output logic [1:0]       err_o
);
  logic     perm_d, rc_d;
  pte_err_e err_d;

  pte_access_eval #(.PTE_W(PTE_W)) u_access (
    .pte_i     (pte_i),
    .priv_i    (priv_i),
    .store_i   (store_i),
    .fetch_i   (fetch_i),
    .perm_ok_o (perm_d)
  );

  pte_rc_eval #(.PTE_W(PTE_W)) u_rc (
    .pte_i   (pte_i),
    .store_i (store_i),
    .rc_ok_o (rc_d)
  );

  // permission failure masks RC failure
  always_comb begin
    if (!perm_d)    err_d = ERR_PERM;
    else if (!rc_d) err_d = ERR_RC;
    else            err_d = ERR_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      perm_ok_o   <= 1'b0;
      rc_ok_o     <= 1'b0;
      err_o       <= ERR_NONE;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        perm_ok_o <= perm_d;
        rc_ok_o   <= rc_d;
        err_o     <= err_d;
      end
    end
  end
endmodule

// File: rtl/pte_perm_check_sva.sv
module pte_perm_check_sva #(
  parameter int unsigned PTE_W = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [PTE_W-1:0] pte_i,
  input logic             priv_i,
  input logic             store_i,
  input logic             fetch_i,
  input logic             rsp_valid_o,
  input logic             perm_ok_o,
  input logic             rc_ok_o,
  input logic [1:0]       err_o
);
  // R1
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  // R1
  no_spurious_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  // R2
  priv_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !priv_i && pte_i[3]) |=> !perm_ok_o);
  // R4
  fetch_cinh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && fetch_i && pte_i[5]) |=> !perm_ok_o);
  // R5
  ref_needed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !pte_i[8]) |=> !rc_ok_o);
  // R6
  perm_err_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !perm_ok_o) |-> (err_o == 2'b01));
  // R6
  rc_err_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && perm_ok_o && !rc_ok_o) |-> (err_o == 2'b10));
  // R6
  no_err_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && perm_ok_o && rc_ok_o) |-> (err_o == 2'b00));
  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> ($stable(err_o) && $stable(perm_ok_o) && $stable(rc_ok_o)));
endmodule

bind pte_perm_check pte_perm_check_sva #(.PTE_W(PTE_W)) u_sva (.*);

// File: tb/pte_perm_check_tb.sv
module pte_perm_check_tb;
  localparam int unsigned PTE_W = 64;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic [PTE_W-1:0] pte = '0;
  logic             priv = 1'b0, store = 1'b0, fetch = 1'b0;
  logic             rsp_valid, perm_ok, rc_ok;
  logic [1:0]       err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pte_perm_check #(.PTE_W(PTE_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .pte_i(pte),
    .priv_i(priv), .store_i(store), .fetch_i(fetch),
    .rsp_valid_o(rsp_valid), .perm_ok_o(perm_ok), .rc_ok_o(rc_ok), .err_o(err)
  );

  // expected state
  logic       e_valid = 1'b0, e_perm = 1'b0, e_rc = 1'b0;
  logic [1:0] e_err = 2'b00;
  string      perm_tag = "R3";
  string      force_tag = "";

  function automatic logic [3:0] ref_fn(input logic [PTE_W-1:0] p,
                                        input logic pr, st, fe);
    logic g, pm, rc;
    logic [1:0] e;
    g  = pr | ~p[3];
    pm = g & (fe ? (p[0] & ~p[5]) : (p[1] | (p[2] & ~st)));
    rc = p[8] & (p[7] | ~st);
    e  = !pm ? 2'b01 : (!rc ? 2'b10 : 2'b00);
    return {pm, rc, e};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_out();
    string ht;
    chk("R1", 64'(rsp_valid), 64'(e_valid));
    ht = e_valid ? "" : "R7";
    chk(force_tag != "" ? force_tag : (ht != "" ? ht : perm_tag), 64'(perm_ok), 64'(e_perm));
    chk(force_tag != "" ? force_tag : (ht != "" ? ht : "R5"), 64'(rc_ok), 64'(e_rc));
    chk(force_tag != "" ? force_tag : (ht != "" ? ht : "R6"), 64'(err), 64'(e_err));
  endtask

  // sample previous result at negedge, then drive next request
  task automatic step(input logic v, input logic [PTE_W-1:0] p,
                      input logic pr, st, fe, input string ftag);
    logic [3:0] r;
    @(negedge clk);
    check_out();
    req_valid = v; pte = p; priv = pr; store = st; fetch = fe;
    e_valid = v;
    if (v) begin
      r = ref_fn(p, pr, st, fe);
      e_perm = r[3]; e_rc = r[2]; e_err = r[1:0];
      perm_tag = (!pr && p[3]) ? "R2" : (fe ? "R4" : "R3");
    end
    force_tag = ftag;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #1;
    // R8 reset state
    chk("R8", 64'(rsp_valid), 64'd0);
    chk("R8", 64'(perm_ok), 64'd0);
    chk("R8", 64'(rc_ok), 64'd0);
    chk("R8", 64'(err), 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // directed corners
    step(1, 64'h0000_0000_0000_0186, 1, 1, 0, "");  // rw, ref, chg: all ok
    step(1, 64'h0000_0000_0000_0104, 1, 1, 0, "");  // read-only store: perm err
    step(1, 64'h0000_0000_0000_0004, 1, 0, 0, "");  // read ok, no ref: RC err
    step(1, 64'h0000_0000_0000_0080, 1, 0, 0, "");  // no rights, no ref: perm err wins
    step(1, 64'h0000_0000_0000_018A, 0, 0, 0, "");  // privileged-only, user: R2
    step(1, 64'h0000_0000_0000_018A, 1, 0, 0, "");  // same, privileged: ok
    step(1, 64'h0000_0000_0000_0101, 1, 0, 1, "");  // exec normal memory
    step(1, 64'h0000_0000_0000_0121, 1, 0, 1, "");  // exec non-idempotent: denied
    step(1, 64'h0000_0000_0000_0131, 1, 0, 1, "");  // exec tolerant I/O: denied
    step(1, 64'h0000_0000_0000_0111, 1, 0, 1, "");  // attr 01: bit5 clear, allowed
    step(1, 64'h0000_0000_0000_0106, 1, 0, 1, "");  // fetch ignores rw/read
    step(1, 64'h0000_0000_0000_0101, 1, 1, 1, "");  // fetch store, no chg: RC err
    step(0, 64'h0000_0000_0000_0000, 0, 0, 0, "");  // idle: hold
    step(0, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 1, "");  // idle with busy inputs: hold
    // R9: reserved bits set vs clear give the same verdict
    step(1, 64'h0000_0000_0000_0186, 1, 1, 0, "R9");
    step(1, 64'hFFFF_FFFF_FFFF_FE50 | 64'h186, 1, 1, 0, "R9");
    step(1, 64'hFFFF_FFFF_FFFF_FE50 | 64'h004, 1, 1, 0, "R9");
    step(1, 64'hFFFF_FFFF_FFFF_FE50 | 64'h001, 1, 0, 1, "R9");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [PTE_W-1:0] rp;
      rp = {$urandom(), $urandom()};
      step(($urandom() % 4) != 0, rp, 1'($urandom()), 1'($urandom()),
           1'($urandom()), "");
    end
    step(0, '0, 0, 0, 0, "");
    step(0, '0, 0, 0, 0, "");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule